// File: doc/BRIEF.md
# SGMII PCS Link Bring-Up Supervisor

This block is a hardware sequencer that takes a serial-gigabit PCS from reset to a usable link without software help. It is the only master on the PCS's 16-bit register port, and it drives the enable of the adapter that sits between the MAC and the PCS. After reset it programs the PCS for serial-gigabit operation, loads the link timer, and performs a soft reset. The soft reset is confirmed by polling, and the polling gives up after a bounded number of attempts.

Once the PCS is out of reset, the block supervises the link in one of two modes.

- **Auto-negotiation mode.** The block waits for negotiation to complete and decodes the partner's speed and duplex. It restarts negotiation on a fixed retry period until negotiation finishes.
- **Forced mode.** The block programs a requested speed and waits for link status.

The block reports four results:

- the adapter enable;
- the resolved speed, with a valid bit;
- a two-bit error code;
- a sticky soft-reset timeout flag.

A mode-change pulse reruns the mode programming with the current mode inputs.

Top module: `sgmii_link_supervisor`

## Requirements
- R1: After reset the block issues four writes in this order: byte address 0x28 (interface mode) ← 0x0003, address 0x00 (control) ← 0x1140, address 0x24 (timer low) ← 0x0D40, address 0x26 (timer high) ← 0x0003.
- R2: A soft reset reads control and writes it back with bit 15 set. It then polls control, with at least POLL_US microseconds between polls, until bit 15 reads 0. After POLL_MAX polls that still see bit 15 set, the block raises `rst_timeout`. When this happens during initialisation, the block stops: it issues no further bus requests, leaves the adapter disabled, and ignores `mode_change`.
- R3: `adapter_en` is 0 from reset until the initial soft reset succeeds. Every mode programming step then sets `adapter_en` to 1 and clears `err_code`, `link_speed_vld` and `rst_timeout`.
- R4: In auto-negotiation mode (`an_enable`=1), the block first sets control bit 12 and then interface-mode bit 1, each by a read-modify-write. It then performs a soft reset and reads status (address 0x02) no sooner than RETRY_US microseconds later.
- R5: When status bit 5 is 1, the block reads partner ability (address 0x0A). The speed field is bits 11:10, with 00=10 Mb/s, 01=100 Mb/s and 10=1000 Mb/s. Duplex is bit 12, with 1 meaning full. A full-duplex partner with a valid speed gives `adapter_en`=1, `link_speed_vld`=1, and `link_speed` equal to that speed field.
- R6: A half-duplex partner with a valid speed gives `err_code`=01 and `adapter_en`=0.
- R7: A partner with speed field 11 gives `err_code`=10 and `adapter_en`=0.
- R8: When status bit 5 is 0, the block sets control bit 9 by a read-modify-write, performs a soft reset, and checks again one retry period later.
- R9: In forced mode, the block clears control bit 12 and interface-mode bit 1. It then writes `req_speed` into interface-mode bits 3:2 (00=10, 01=100, 10=1000) and soft-resets the PCS. When status bit 2 reads 1, `link_speed_vld` becomes 1 and `link_speed` equals `req_speed`.
- R10: In forced mode with status bit 2 at 0, the block makes no write and re-reads status at least RETRY_US microseconds later, until the link comes up.
- R11: In forced mode, `req_speed`=11 ends the sequence after the interface-mode read, without writing the speed field, and sets `err_code`=11.
- R12: A `mode_change` pulse is held pending. It is acted on once the sequence is finished or waiting for a retry.
- R13: `reg_req` stays high, with `reg_we`, `reg_addr` and `reg_wdata` unchanged, until `reg_ack`. It falls in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| an_enable | input | 1 | 1 selects auto-negotiation mode, 0 selects forced mode |
| req_speed | input | 2 | Requested forced speed code |
| mode_change | input | 1 | One-cycle request to rerun mode programming |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 for a write, 0 for a read |
| reg_addr | output | 8 | Register byte address |
| reg_wdata | output | 16 | Write data |
| reg_ack | input | 1 | Access acknowledge |
| reg_rdata | input | 16 | Read data, valid with reg_ack |
| adapter_en | output | 1 | Adapter enable |
| link_speed | output | 2 | Resolved speed code |
| link_speed_vld | output | 1 | link_speed holds a resolved link |
| err_code | output | 2 | 00 none, 01 half duplex, 10 invalid partner, 11 unsupported request |
| rst_timeout | output | 1 | Soft reset did not complete within POLL_MAX polls |

## Verification
The bench goes after the corner cases of this block. For each one, the likely fault is stated.

- **Read-modify-write values.** Every read-modify-write must carry the bits the PCS actually holds. A design that wrote constants would send the wrong control word once restart or a forced mode has changed bits.
- **Soft-reset timeout.** A stuck reset bit is used to show that polling stops after exactly POLL_MAX polls. A design with an off-by-one poll count, or one that carried on after an initialisation timeout, would show an extra control read or more bus traffic.
- **Partner decode.** Partners with half duplex and with speed 11 are applied. A design that missed either would enable the adapter.
- **Retry timing.** Negotiation that is not yet complete must cause exactly one restart write followed by one soft reset. Forced mode with the link down must re-read status no sooner than the retry period, and a design without the wait would poll status back to back.
- **Unsupported forced speed.** A design that did not guard the speed code would issue the speed write.

// File: rtl/sgls_pkg.sv
package sgls_pkg;

  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_STAT   = 8'h02;
  localparam logic [7:0] A_PART   = 8'h0A;
  localparam logic [7:0] A_TMR_LO = 8'h24;
  localparam logic [7:0] A_TMR_HI = 8'h26;
  localparam logic [7:0] A_IFMODE = 8'h28;

  localparam logic [15:0] V_IFMODE_INIT = 16'h0003;
  localparam logic [15:0] V_CTRL_INIT   = 16'h1140;
  localparam logic [15:0] V_TMR_LO      = 16'h0D40;
  localparam logic [15:0] V_TMR_HI      = 16'h0003;

  localparam logic [15:0] M_SOFT_RST = 16'h8000;
  localparam logic [15:0] M_AN_EN    = 16'h1000;
  localparam logic [15:0] M_AN_RESTART = 16'h0200;
  localparam logic [15:0] M_IF_SGMII_AN = 16'h0002;
  localparam logic [15:0] M_IF_SPEED = 16'h000C;

  localparam logic [1:0] ERR_NONE  = 2'b00;
  localparam logic [1:0] ERR_HALF  = 2'b01;
  localparam logic [1:0] ERR_INVAL = 2'b10;
  localparam logic [1:0] ERR_UNSUP = 2'b11;

  typedef enum logic [4:0] {
    ST_I_IFM, ST_I_CTL, ST_I_TLO, ST_I_THI,
    ST_SR_RD, ST_SR_WR, ST_SR_WAIT, ST_SR_POLL,
    ST_HALT, ST_M_EN,
    ST_A_RD_CTL, ST_A_WR_CTL, ST_A_RD_IFM, ST_A_WR_IFM,
    ST_F_RD_CTL, ST_F_WR_CTL, ST_F_RD_IFM, ST_F_WR_IFM,
    ST_F_RD_SPD, ST_F_WR_SPD,
    ST_RETRY, ST_CHK_STAT, ST_A_RD_PART, ST_A_RD_RST, ST_A_WR_RST,
    ST_DONE
  } state_e;

  typedef enum logic {RET_INIT, RET_SUPV} ret_e;

endpackage

// File: rtl/sgls_rst_sync.sv
module sgls_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/sgls_regport.sv
module sgls_regport #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_wdata,
  output logic          done,
  output logic [DW-1:0] rd_q,
  output logic          reg_req,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic          reg_ack,
  input  logic [DW-1:0] reg_rdata
);
  logic          req_q,   req_d;
  logic          we_q,    we_d;
  logic [AW-1:0] addr_q,  addr_d;
  logic [DW-1:0] wdat_q,  wdat_d;
  logic [DW-1:0] rdat_q,  rdat_d;
  logic          acc;

  assign acc  = req_q & reg_ack;
  assign done = acc;

  always_comb begin
    req_d  = req_q;
    we_d   = we_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    rdat_d = rdat_q;
    if (acc) begin
      req_d  = 1'b0;
      rdat_d = reg_rdata;
    end else if (go && !req_q) begin
      req_d  = 1'b1;
      we_d   = go_we;
      addr_d = go_addr;
      wdat_d = go_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wdat_q <= '0;
      rdat_q <= '0;
    end else begin
      req_q  <= req_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
      rdat_q <= rdat_d;
    end
  end

  assign reg_req   = req_q;
  assign reg_we    = we_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdat_q;
  assign rd_q      = rdat_q;
endmodule

// File: rtl/sgls_delay.sv
module sgls_delay #(
  parameter int CLK_HZ = 125_000_000,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dur_us,
  output logic          expired
);
  localparam int CYC_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int CW     = $clog2(CYC_US + 1);

  logic [CW-1:0] cyc_q, cyc_d;
  logic [DW-1:0] rem_q, rem_d;
  logic          busy_q, busy_d;
  logic          us_tick;

  assign us_tick = busy_q && (cyc_q == CW'(CYC_US - 1));
  assign expired = us_tick && (rem_q <= DW'(1));

  always_comb begin
    cyc_d  = cyc_q;
    rem_d  = rem_q;
    busy_d = busy_q;
    if (start) begin
      cyc_d  = '0;
      rem_d  = dur_us;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (us_tick) begin
        cyc_d = '0;
        if (expired) busy_d = 1'b0;
        else         rem_d  = rem_q - DW'(1);
      end else begin
        cyc_d = cyc_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cyc_q  <= cyc_d;
      rem_q  <= rem_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/sgmii_link_supervisor.sv
module sgmii_link_supervisor
  import sgls_pkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int POLL_US  = 1,
  parameter int POLL_MAX = 100,
  parameter int RETRY_US = 20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        an_enable,
  input  logic [1:0]  req_speed,
  input  logic        mode_change,
  output logic        reg_req,
  output logic        reg_we,
  output logic [7:0]  reg_addr,
  output logic [15:0] reg_wdata,
  input  logic        reg_ack,
  input  logic [15:0] reg_rdata,
  output logic        adapter_en,
  output logic [1:0]  link_speed,
  output logic        link_speed_vld,
  output logic [1:0]  err_code,
  output logic        rst_timeout
);
  localparam int MAXUS = (RETRY_US > POLL_US) ? RETRY_US : POLL_US;
  localparam int DW    = $clog2(MAXUS + 1);
  localparam int PW    = $clog2(POLL_MAX + 1);

  logic rst_i_n;

  state_e      state_q, state_d;
  ret_e        ret_q, ret_d;
  logic        issued_q, issued_d;
  logic [PW-1:0] poll_q, poll_d;
  logic        aen_q, aen_d;
  logic [1:0]  spd_q, spd_d;
  logic        vld_q, vld_d;
  logic [1:0]  err_q, err_d;
  logic        tmo_q, tmo_d;
  logic        man_q, man_d;
  logic [1:0]  mspd_q, mspd_d;
  logic        pend_q, pend_d;

  logic        is_bus, b_we, go, done;
  logic [7:0]  b_addr;
  logic [15:0] b_wdata, rd_q;
  logic        dly_start, dly_exp;
  logic [DW-1:0] dly_dur;

  sgls_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  sgls_regport #(.AW(8), .DW(16)) u_port (
    .clk(clk), .rst_n(rst_i_n),
    .go(go), .go_we(b_we), .go_addr(b_addr), .go_wdata(b_wdata),
    .done(done), .rd_q(rd_q),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata)
  );

  sgls_delay #(.CLK_HZ(CLK_HZ), .DW(DW)) u_dly (
    .clk(clk), .rst_n(rst_i_n), .start(dly_start),
    .dur_us(dly_dur), .expired(dly_exp)
  );

  // bus operation selected by the current step
  always_comb begin
    is_bus  = 1'b1;
    b_we    = 1'b0;
    b_addr  = A_CTRL;
    b_wdata = '0;
    unique case (state_q)
      ST_I_IFM:     begin b_we = 1'b1; b_addr = A_IFMODE; b_wdata = V_IFMODE_INIT; end
      ST_I_CTL:     begin b_we = 1'b1; b_addr = A_CTRL;   b_wdata = V_CTRL_INIT;   end
      ST_I_TLO:     begin b_we = 1'b1; b_addr = A_TMR_LO; b_wdata = V_TMR_LO;      end
      ST_I_THI:     begin b_we = 1'b1; b_addr = A_TMR_HI; b_wdata = V_TMR_HI;      end
      ST_SR_RD, ST_SR_POLL, ST_A_RD_CTL, ST_F_RD_CTL, ST_A_RD_RST: b_addr = A_CTRL;
      ST_SR_WR:     begin b_we = 1'b1; b_wdata = rd_q | M_SOFT_RST; end
      ST_A_WR_CTL:  begin b_we = 1'b1; b_wdata = rd_q | M_AN_EN; end
      ST_F_WR_CTL:  begin b_we = 1'b1; b_wdata = rd_q & ~M_AN_EN; end
      ST_A_WR_RST:  begin b_we = 1'b1; b_wdata = rd_q | M_AN_RESTART; end
      ST_A_RD_IFM, ST_F_RD_IFM, ST_F_RD_SPD: b_addr = A_IFMODE;
      ST_A_WR_IFM:  begin b_we = 1'b1; b_addr = A_IFMODE; b_wdata = rd_q | M_IF_SGMII_AN; end
      ST_F_WR_IFM:  begin b_we = 1'b1; b_addr = A_IFMODE; b_wdata = rd_q & ~M_IF_SGMII_AN; end
      ST_F_WR_SPD:  begin
        b_we    = 1'b1;
        b_addr  = A_IFMODE;
        b_wdata = (rd_q & ~M_IF_SPEED) | {12'h000, mspd_q, 2'b00};
      end
      ST_CHK_STAT:  b_addr = A_STAT;
      ST_A_RD_PART: b_addr = A_PART;
      default:      is_bus = 1'b0;
    endcase
  end

  assign go = is_bus && !issued_q;

  // sequencing
  always_comb begin
    state_d   = state_q;
    ret_d     = ret_q;
    issued_d  = issued_q;
    poll_d    = poll_q;
    aen_d     = aen_q;
    spd_d     = spd_q;
    vld_d     = vld_q;
    err_d     = err_q;
    tmo_d     = tmo_q;
    man_d     = man_q;
    mspd_d    = mspd_q;
    pend_d    = pend_q;
    dly_start = 1'b0;
    dly_dur   = DW'(RETRY_US);

    if (done)    issued_d = 1'b0;
    else if (go) issued_d = 1'b1;

    unique case (state_q)
      ST_I_IFM: if (done) state_d = ST_I_CTL;
      ST_I_CTL: if (done) state_d = ST_I_TLO;
      ST_I_TLO: if (done) state_d = ST_I_THI;
      ST_I_THI: if (done) begin state_d = ST_SR_RD; ret_d = RET_INIT; end
      ST_SR_RD: if (done) state_d = ST_SR_WR;
      ST_SR_WR: if (done) begin
        state_d   = ST_SR_WAIT;
        poll_d    = '0;
        dly_start = 1'b1;
        dly_dur   = DW'(POLL_US);
      end
      ST_SR_WAIT: if (dly_exp) state_d = ST_SR_POLL;
      ST_SR_POLL: if (done) begin
        if (!reg_rdata[15]) begin
          if (ret_q == RET_INIT) begin
            state_d = ST_M_EN;
          end else begin
            state_d   = ST_RETRY;
            dly_start = 1'b1;
          end
        end else if (poll_q == PW'(POLL_MAX - 1)) begin
          tmo_d = 1'b1;
          if (ret_q == RET_INIT) begin
            state_d = ST_HALT;
          end else begin
            state_d   = ST_RETRY;
            dly_start = 1'b1;
          end
        end else begin
          poll_d    = poll_q + PW'(1);
          state_d   = ST_SR_WAIT;
          dly_start = 1'b1;
          dly_dur   = DW'(POLL_US);
        end
      end
      ST_HALT: state_d = ST_HALT;
      ST_M_EN: begin
        aen_d   = 1'b1;
        err_d   = ERR_NONE;
        vld_d   = 1'b0;
        tmo_d   = 1'b0;
        man_d   = an_enable;
        mspd_d  = req_speed;
        pend_d  = 1'b0;
        state_d = an_enable ? ST_A_RD_CTL : ST_F_RD_CTL;
      end
      ST_A_RD_CTL: if (done) state_d = ST_A_WR_CTL;
      ST_A_WR_CTL: if (done) state_d = ST_A_RD_IFM;
      ST_A_RD_IFM: if (done) state_d = ST_A_WR_IFM;
      ST_A_WR_IFM: if (done) begin state_d = ST_SR_RD; ret_d = RET_SUPV; end
      ST_F_RD_CTL: if (done) state_d = ST_F_WR_CTL;
      ST_F_WR_CTL: if (done) state_d = ST_F_RD_IFM;
      ST_F_RD_IFM: if (done) state_d = ST_F_WR_IFM;
      ST_F_WR_IFM: if (done) state_d = ST_F_RD_SPD;
      ST_F_RD_SPD: if (done) begin
        if (mspd_q == 2'b11) begin
          err_d   = ERR_UNSUP;
          state_d = ST_DONE;
        end else begin
          state_d = ST_F_WR_SPD;
        end
      end
      ST_F_WR_SPD: if (done) begin state_d = ST_SR_RD; ret_d = RET_SUPV; end
      ST_RETRY: begin
        if (pend_q)       state_d = ST_M_EN;
        else if (dly_exp) state_d = ST_CHK_STAT;
      end
      ST_CHK_STAT: if (done) begin
        if (man_q) begin
          state_d = reg_rdata[5] ? ST_A_RD_PART : ST_A_RD_RST;
        end else if (reg_rdata[2]) begin
          aen_d   = 1'b1;
          spd_d   = mspd_q;
          vld_d   = 1'b1;
          state_d = ST_DONE;
        end else begin
          state_d   = ST_RETRY;
          dly_start = 1'b1;
        end
      end
      ST_A_RD_PART: if (done) begin
        state_d = ST_DONE;
        if (reg_rdata[12] && reg_rdata[11:10] != 2'b11) begin
          aen_d = 1'b1;
          spd_d = reg_rdata[11:10];
          vld_d = 1'b1;
          err_d = ERR_NONE;
        end else if (!reg_rdata[12] && reg_rdata[11:10] != 2'b11) begin
          aen_d = 1'b0;
          err_d = ERR_HALF;
        end else begin
          aen_d = 1'b0;
          err_d = ERR_INVAL;
        end
      end
      ST_A_RD_RST: if (done) state_d = ST_A_WR_RST;
      ST_A_WR_RST: if (done) begin state_d = ST_SR_RD; ret_d = RET_SUPV; end
      ST_DONE: if (pend_q) state_d = ST_M_EN;
      default: state_d = ST_HALT;
    endcase

    if (mode_change) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q  <= ST_I_IFM;
      ret_q    <= RET_INIT;
      issued_q <= 1'b0;
      poll_q   <= '0;
      aen_q    <= 1'b0;
      spd_q    <= 2'b00;
      vld_q    <= 1'b0;
      err_q    <= ERR_NONE;
      tmo_q    <= 1'b0;
      man_q    <= 1'b0;
      mspd_q   <= 2'b00;
      pend_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      ret_q    <= ret_d;
      issued_q <= issued_d;
      poll_q   <= poll_d;
      aen_q    <= aen_d;
      spd_q    <= spd_d;
      vld_q    <= vld_d;
      err_q    <= err_d;
      tmo_q    <= tmo_d;
      man_q    <= man_d;
      mspd_q   <= mspd_d;
      pend_q   <= pend_d;
    end
  end

  assign adapter_en     = aen_q;
  assign link_speed     = spd_q;
  assign link_speed_vld = vld_q;
  assign err_code       = err_q;
  assign rst_timeout    = tmo_q;
endmodule

// File: rtl/sgls_checker.sv
module sgls_checker
  import sgls_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        reg_req,
  input logic        reg_we,
  input logic [7:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        reg_ack,
  input logic        adapter_en,
  input logic        link_speed_vld,
  input logic [1:0]  err_code,
  input logic        rst_timeout,
  input state_e      state_q
);
  // R13: request held with stable fields until acknowledged
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_ack) |=> (reg_req && $stable(reg_we) && $stable(reg_addr) && $stable(reg_wdata)));

  // R13: request withdrawn right after acknowledge
  a_r13_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_ack) |=> !reg_req);

  // R5: a resolved speed implies the adapter is on
  a_r5_vld_en: assert property (@(posedge clk) disable iff (!rst_n)
    link_speed_vld |-> adapter_en);

  // R6 / R7: partner errors keep the adapter off
  a_r6_r7_err_off: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == ERR_HALF || err_code == ERR_INVAL) |-> !adapter_en);

  // R2: halted after initial timeout, quiet and disabled
  a_r2_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |-> (!reg_req && !adapter_en && rst_timeout));
endmodule

bind sgmii_link_supervisor sgls_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
  .adapter_en(adapter_en), .link_speed_vld(link_speed_vld),
  .err_code(err_code), .rst_timeout(rst_timeout), .state_q(state_q)
);

// File: tb/sgmii_link_supervisor_tb.sv
module sgmii_link_supervisor_tb;
  localparam int CLK_HZ = 4_000_000;
  localparam int POLL_MAX = 5;
  localparam int RETRY_US = 30;
  localparam int CYC_US = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic an_enable = 1'b1;
  logic [1:0] req_speed = 2'b00;
  logic mode_change = 1'b0;
  logic reg_req, reg_we, reg_ack;
  logic [7:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic adapter_en, link_speed_vld, rst_timeout;
  logic [1:0] link_speed, err_code;

  always #4 clk = ~clk;

  sgmii_link_supervisor #(.CLK_HZ(CLK_HZ), .POLL_US(1), .POLL_MAX(POLL_MAX),
                          .RETRY_US(RETRY_US)) u_dut (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .req_speed(req_speed),
    .mode_change(mode_change), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
    .reg_rdata(reg_rdata), .adapter_en(adapter_en), .link_speed(link_speed),
    .link_speed_vld(link_speed_vld), .err_code(err_code), .rst_timeout(rst_timeout)
  );

  int tests = 0;
  int fails = 0;
  logic [23:0] exp_q[$];

  // PCS register model
  logic [15:0] m_ctrl, m_ifm, m_tlo, m_thi, m_part;
  logic m_an_done = 1'b0;
  logic m_link = 1'b0;
  int   rst_k = 2;
  int   rst_left = 0;
  int   ctrl_reads = 0;
  int   stat_reads = 0;
  int   restarts = 0;
  longint cyc = 0;
  longint last_ctrl_rd = 0;
  longint last_stat_rd = 0;
  longint min_ctrl_gap = 1000000;
  longint min_stat_gap = 1000000;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [15:0] d);
    exp_q.push_back({a, d});
  endtask

  initial begin
    reg_ack = 1'b0;
    reg_rdata = '0;
    m_ctrl = '0; m_ifm = '0; m_tlo = '0; m_thi = '0; m_part = '0;
    forever begin
      @(posedge clk);
      cyc++;
      if (!rst_n) begin
        m_ctrl = '0; m_ifm = '0; m_tlo = '0; m_thi = '0;
        rst_left = 0;
        reg_ack <= 1'b0;
      end else if (reg_req && !reg_ack) begin
        reg_ack <= 1'b1;
        if (reg_we) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1/R13 unexpected write", {8'h0, reg_addr, reg_wdata}, 32'h0);
          end else begin
            logic [23:0] e;
            e = exp_q.pop_front();
            chk(e == {reg_addr, reg_wdata}, "R1/R2/R4/R8/R9 write",
                {8'h0, reg_addr, reg_wdata}, {8'h0, e});
          end
          case (reg_addr)
            8'h00: begin
              m_ctrl = reg_wdata;
              if (reg_wdata[15]) rst_left = rst_k;
              if (reg_wdata[9] && !reg_wdata[15]) restarts++;
            end
            8'h24: m_tlo = reg_wdata;
            8'h26: m_thi = reg_wdata;
            8'h28: m_ifm = reg_wdata;
            default: ;
          endcase
        end else begin
          case (reg_addr)
            8'h00: begin
              reg_rdata <= m_ctrl;
              ctrl_reads++;
              if (cyc - last_ctrl_rd < min_ctrl_gap && m_ctrl[15]) min_ctrl_gap = cyc - last_ctrl_rd;
              last_ctrl_rd = cyc;
              if (rst_left > 0) begin
                rst_left--;
                if (rst_left == 0) m_ctrl = m_ctrl & 16'h7DFF;
              end
            end
            8'h02: begin
              reg_rdata <= {10'h0, m_an_done, 2'b00, m_link, 2'b00};
              stat_reads++;
              if (stat_reads > 1 && cyc - last_stat_rd < min_stat_gap)
                min_stat_gap = cyc - last_stat_rd;
              last_stat_rd = cyc;
            end
            8'h0A: reg_rdata <= m_part;
            8'h28: reg_rdata <= m_ifm;
            default: reg_rdata <= 16'h0;
          endcase
        end
      end else begin
        reg_ack <= 1'b0;
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_mode(input logic an, input logic [1:0] spd);
    @(negedge clk);
    an_enable = an;
    req_speed = spd;
    mode_change = 1'b1;
    @(negedge clk);
    mode_change = 1'b0;
  endtask

  task automatic chk_drained(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic push_an_prog(input logic [15:0] ctl, input logic [15:0] ifm);
    push(8'h00, ctl | 16'h1000);
    push(8'h28, ifm | 16'h0002);
    push(8'h00, ctl | 16'h9000);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none

    // reset state
    an_enable = 1'b1;
    m_part = 16'h1800;
    m_an_done = 1'b1;
    wait_cyc(3);
    chk(!reg_req && !adapter_en && !link_speed_vld && err_code == 2'b00 && !rst_timeout,
        "R3 reset state", {reg_req, adapter_en, link_speed_vld, err_code, rst_timeout}, 0);

    // init + auto-negotiation, 1000 full
    push(8'h28, 16'h0003); push(8'h00, 16'h1140);
    push(8'h24, 16'h0D40); push(8'h26, 16'h0003);
    push(8'h00, 16'h9140);
    push_an_prog(16'h1140, 16'h0003);
    rst_n = 1'b1;
    wait_cyc(20);
    chk(!adapter_en, "R3 adapter off before soft reset done", adapter_en, 0);
    wait_cyc(600);
    chk_drained("R1 R4 write sequence complete");
    chk(adapter_en && link_speed_vld && link_speed == 2'b10 && err_code == 2'b00,
        "R5 1000 full", {adapter_en, link_speed_vld, link_speed, err_code}, 6'b111000);

    // half duplex 100
    m_part = 16'h0400;
    push_an_prog(16'h1140, 16'h0003);
    pulse_mode(1'b1, 2'b00);
    wait_cyc(600);
    chk_drained("R12 R6 mode change writes");
    chk(!adapter_en && err_code == 2'b01 && !link_speed_vld, "R6 half duplex",
        {adapter_en, err_code, link_speed_vld}, 4'b0010);

    // invalid speed field
    m_part = 16'h1C00;
    push_an_prog(16'h1140, 16'h0003);
    pulse_mode(1'b1, 2'b00);
    wait_cyc(600);
    chk_drained("R7 writes");
    chk(!adapter_en && err_code == 2'b10, "R7 invalid partner",
        {adapter_en, err_code}, 3'b010);

    // incomplete negotiation, one restart, then 10 full
    m_an_done = 1'b0;
    m_part = 16'h1000;
    restarts = 0;
    push_an_prog(16'h1140, 16'h0003);
    push(8'h00, 16'h1340);
    push(8'h00, 16'h9340);
    pulse_mode(1'b1, 2'b00);
    while (restarts == 0) @(negedge clk);
    m_an_done = 1'b1;
    wait_cyc(700);
    chk_drained("R8 restart and soft reset writes");
    chk(restarts == 1, "R8 restart count", restarts, 1);
    chk(adapter_en && link_speed_vld && link_speed == 2'b00 && err_code == 2'b00,
        "R5 10 full after retry", {adapter_en, link_speed_vld, link_speed, err_code}, 6'b110000);

    // forced 100, link down then up
    m_link = 1'b0;
    push(8'h00, 16'h0140);
    push(8'h28, 16'h0001);
    push(8'h28, 16'h0005);
    push(8'h00, 16'h8140);
    pulse_mode(1'b0, 2'b01);
    stat_reads = 0;
    min_stat_gap = 1000000;
    wait_cyc(700);
    chk_drained("R9 forced programming writes");
    chk(!link_speed_vld, "R10 no link yet", link_speed_vld, 0);
    chk(stat_reads >= 3, "R10 status re-read", stat_reads, 3);
    chk(min_stat_gap >= RETRY_US * CYC_US, "R10 retry spacing", min_stat_gap, RETRY_US * CYC_US);
    m_link = 1'b1;
    wait_cyc(300);
    chk(adapter_en && link_speed_vld && link_speed == 2'b01, "R9 forced link up",
        {adapter_en, link_speed_vld, link_speed}, 4'b1101);

    // forced unsupported speed
    push(8'h00, 16'h0140);
    push(8'h28, 16'h0005);
    pulse_mode(1'b0, 2'b11);
    wait_cyc(300);
    chk_drained("R11 no speed write");
    chk(err_code == 2'b11 && !link_speed_vld, "R11 unsupported request",
        {err_code, link_speed_vld}, 3'b110);
    chk(m_ifm == 16'h0005, "R11 mode register untouched", m_ifm, 16'h0005);

    // stuck soft reset during init
    @(negedge clk);
    rst_n = 1'b0;
    rst_k = 1000;
    wait_cyc(3);
    ctrl_reads = 0;
    min_ctrl_gap = 1000000;
    push(8'h28, 16'h0003); push(8'h00, 16'h1140);
    push(8'h24, 16'h0D40); push(8'h26, 16'h0003);
    push(8'h00, 16'h9140);
    rst_n = 1'b1;
    wait_cyc(300);
    chk_drained("R1 R2 init writes before timeout");
    chk(ctrl_reads == 1 + POLL_MAX, "R2 poll count", ctrl_reads, 1 + POLL_MAX);
    chk(min_ctrl_gap >= CYC_US, "R2 poll spacing", min_ctrl_gap, CYC_US);
    chk(rst_timeout && !adapter_en, "R2 timeout flag", {rst_timeout, adapter_en}, 2'b10);
    pulse_mode(1'b1, 2'b00);
    wait_cyc(300);
    chk(ctrl_reads == 1 + POLL_MAX && !adapter_en && rst_timeout,
        "R2 mode change ignored after halt", ctrl_reads, 1 + POLL_MAX);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule